// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one parallel character per handshake into an asynchronous serial frame on a single output line. The frame shape is chosen by a few mode inputs: a two-bit frame mode picks 7 or 8 character bits and one or two stop bits. A parity-disable bit and a two-bit parity mode add an optional parity bit, which can be forced low, forced high, odd or even. A break-enable input forces the whole frame low.

Bit timing comes from an external baud tick: every bit stays on the line for exactly one tick period. A character is accepted only on a tick cycle when the line is free. A free line means no frame is in progress, or the current frame is in its last stop bit, so frames can run back to back. All mode settings and the data word are captured when a frame is accepted.

The block only transmits in asynchronous mode. While the synchronous-mode select is high it accepts nothing. In asynchronous mode its separate bit-length field has no effect.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, busy is low, and the line stays high with busy low while no frame runs.
- R2: A frame is a low start bit, then the character bits least significant first, then the parity bit if enabled, then high stop bits.
- R3: Frame mode (bit 1 = 8 character bits when set, otherwise 7; bit 0 = two stop bits when set, otherwise one) sets the frame shape. In 7-bit modes, data bit 7 is not sent.
- R4: With parity-disable at 1, no parity bit is sent, whatever the parity mode holds.
- R5: With parity enabled, parity mode 00 sends a parity bit of 0 and mode 01 sends a parity bit of 1.
- R6: With parity enabled, mode 10 makes the count of ones over the character and parity bits odd, and mode 11 makes it even.
- R7: With break enabled, every bit from the start bit through the last stop bit is 0. The frame length is unchanged, and the line goes high again after the frame.
- R8: While the synchronous-mode select is 0, the bit-length field has no effect on the frame.
- R9: While the synchronous-mode select is 1, in_ready stays low and no frame starts.
- R10: Data, frame mode, parity and break settings are captured when a frame is accepted. Changes during a frame do not alter that frame.
- R11: Each bit lasts exactly one baud tick period. in_ready is high only in a tick cycle when the line is idle or sending the last stop bit, so back-to-back frames have no gap.
- R12: busy is high from the first cycle of the start bit through the last cycle of the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character accepted this cycle if in_valid |
| in_data | input | 8 | Character, bit 0 sent first |
| frame_mode | input | 2 | Bit 1: 8-bit character; bit 0: two stop bits |
| par_off | input | 1 | 1 removes the parity bit |
| par_sel | input | 2 | 00 zero, 01 one, 10 odd, 11 even |
| brk_en | input | 1 | Drive the whole frame low |
| sync_sel | input | 1 | 1 selects synchronous mode (transmitter inert) |
| bit_len | input | 3 | Synchronous bit length, unused in asynchronous mode |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that baud_tick is a single-cycle pulse. They also assume that in_valid, once raised, is held with stable data and settings until the handshake completes. The bench produces ticks from a divider that gives one-cycle pulses, and each task keeps its inputs fixed until it sees in_ready. The only changes during a frame are those made on purpose after acceptance. Those changes test that settings are captured when a frame is accepted, and the assertions do not depend on them.

// File: rtl/uart_tx_pkg.sv
// Shared types for the UART frame transmitter.
// Assumes parity selector encoding 00 zero, 01 one, 10 odd, 11 even.
package uart_tx_pkg;
    typedef enum logic [1:0] {
        PAR_ZERO = 2'b00,
        PAR_ONE  = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic      long_char;
        logic      two_stop;
        logic      par_on;
        par_mode_e par;
        logic      brk;
    } frame_cfg_t;
endpackage

// File: rtl/uart_tx_cfg_decode.sv
// Decodes the raw mode inputs into a frame configuration record.
// Assumes the synchronous bit-length field is irrelevant here and never sees it.
module uart_tx_cfg_decode
    import uart_tx_pkg::*;
(
    input  logic [1:0] frame_mode,
    input  logic       par_off,
    input  logic [1:0] par_sel,
    input  logic       brk_en,
    output frame_cfg_t cfg
);
    // Map the mode pins onto named configuration fields.
    always_comb begin
        cfg.long_char = frame_mode[1];
        cfg.two_stop  = frame_mode[0];
        cfg.par_on    = ~par_off;
        cfg.par       = par_mode_e'(par_sel);
        cfg.brk       = brk_en;
    end
endmodule

// File: rtl/uart_tx_parity.sv
// Computes the parity bit for a character of short or long length.
// Assumes the short length is not larger than the long length.
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int CHAR_W_LONG  = 8,
    parameter int CHAR_W_SHORT = 7
) (
    input  logic [CHAR_W_LONG-1:0] data,
    input  logic                   long_char,
    input  par_mode_e              mode,
    output logic                   par_bit
);
    logic [CHAR_W_LONG-1:0] mask;
    logic                   ones_odd;

    // Keep only the character bits that are sent.
    always_comb begin
        for (int i = 0; i < CHAR_W_LONG; i++) begin
            mask[i] = long_char || (i < CHAR_W_SHORT);
        end
        ones_odd = ^(data & mask);
    end

    // Pick the parity value for the selected mode.
    always_comb begin
        unique case (mode)
            PAR_ZERO: par_bit = 1'b0;
            PAR_ONE:  par_bit = 1'b1;
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_EVEN: par_bit = ones_odd;
            default:  par_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_tx_frame_build.sv
// Assembles the complete frame as a bit vector (position 0 is sent first),
// together with its length in bits. Positions past the length are ones.
// Assumes FRAME_W holds start, the long character, parity and STOP_MAX stops.
module uart_tx_frame_build
    import uart_tx_pkg::*;
#(
    parameter int CHAR_W_LONG  = 8,
    parameter int CHAR_W_SHORT = 7,
    parameter int STOP_MAX     = 2,
    parameter int FRAME_W      = 1 + CHAR_W_LONG + 1 + STOP_MAX,
    parameter int CNT_W        = $clog2(FRAME_W + 1)
) (
    input  logic [CHAR_W_LONG-1:0] data,
    input  frame_cfg_t             cfg,
    output logic [FRAME_W-1:0]     frame,
    output logic [CNT_W-1:0]       len
);
    logic par_bit;
    int   n_char;
    int   n_stop;
    int   n_par;

    uart_tx_parity #(
        .CHAR_W_LONG (CHAR_W_LONG),
        .CHAR_W_SHORT(CHAR_W_SHORT)
    ) u_par (
        .data     (data),
        .long_char(cfg.long_char),
        .mode     (cfg.par),
        .par_bit  (par_bit)
    );

    // Field sizes for the selected mode.
    always_comb begin
        n_char = cfg.long_char ? CHAR_W_LONG : CHAR_W_SHORT;
        n_stop = cfg.two_stop ? STOP_MAX : 1;
        n_par  = cfg.par_on ? 1 : 0;
        len    = CNT_W'(1 + n_char + n_par + n_stop);
    end

    // Place start, character, parity and stop bits; break clears all.
    always_comb begin
        frame = '1;
        frame[0] = 1'b0;
        for (int p = 1; p < FRAME_W; p++) begin
            if (p <= n_char) begin
                frame[p] = data[p-1];
            end else if ((n_par == 1) && (p == n_char + 1)) begin
                frame[p] = par_bit;
            end
        end
        if (cfg.brk) begin
            frame = '0;
        end
    end
endmodule

// File: rtl/uart_tx_seq.sv
// Shifts a loaded frame onto the line, one bit per baud tick.
// Assumes load is only raised in a tick cycle and len is at least 1.
module uart_tx_seq #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   len,
    output logic               txd,
    output logic               active,
    output logic               last
);
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   rem_q;

    // Advance the line by one bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd    <= 1'b1;
            active <= 1'b0;
            sh_q   <= '1;
            rem_q  <= '0;
        end else if (tick) begin
            if (load) begin
                txd    <= frame[0];
                sh_q   <= {1'b1, frame[FRAME_W-1:1]};
                rem_q  <= len - CNT_W'(1);
                active <= 1'b1;
            end else if (active && (rem_q != '0)) begin
                txd   <= sh_q[0];
                sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                rem_q <= rem_q - CNT_W'(1);
            end else begin
                txd    <= 1'b1;
                active <= 1'b0;
            end
        end
    end

    // Flag the final bit of the frame.
    assign last = active && (rem_q == '0);
endmodule

// File: rtl/uart_frame_tx.sv
// UART frame transmitter top: handshake, configuration capture, sequencing.
// Assumes baud_tick is a one-cycle pulse; the synchronous bit-length field is unused.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int CHAR_W_LONG  = 8,
    parameter int CHAR_W_SHORT = 7,
    parameter int STOP_MAX     = 2,
    parameter int LEN_FIELD_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   baud_tick,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [CHAR_W_LONG-1:0] in_data,
    input  logic [1:0]             frame_mode,
    input  logic                   par_off,
    input  logic [1:0]             par_sel,
    input  logic                   brk_en,
    input  logic                   sync_sel,
    input  logic [LEN_FIELD_W-1:0] bit_len,
    output logic                   txd,
    output logic                   busy
);
    localparam int FRAME_W = 1 + CHAR_W_LONG + 1 + STOP_MAX;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    frame_cfg_t         cfg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;
    logic               active;
    logic               last;
    logic               accept;
    logic               unused_len;

    // The bit-length field only matters in synchronous mode.
    assign unused_len = ^bit_len;

    uart_tx_cfg_decode u_cfg (
        .frame_mode(frame_mode),
        .par_off   (par_off),
        .par_sel   (par_sel),
        .brk_en    (brk_en),
        .cfg       (cfg)
    );

    uart_tx_frame_build #(
        .CHAR_W_LONG (CHAR_W_LONG),
        .CHAR_W_SHORT(CHAR_W_SHORT),
        .STOP_MAX    (STOP_MAX),
        .FRAME_W     (FRAME_W),
        .CNT_W       (CNT_W)
    ) u_build (
        .data (in_data),
        .cfg  (cfg),
        .frame(frame),
        .len  (len)
    );

    // Accept only on a tick, in asynchronous mode, when the line frees up.
    always_comb begin
        in_ready = baud_tick && !sync_sel && (!active || last);
        accept   = in_valid && in_ready;
    end

    uart_tx_seq #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .load  (accept),
        .frame (frame),
        .len   (len),
        .txd   (txd),
        .active(active),
        .last  (last)
    );

    assign busy = active;
endmodule

// File: rtl/uart_frame_tx_chk.sv
// Protocol checker for uart_frame_tx, attached by bind.
// Assumes baud_tick is a single-cycle pulse.
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic sync_sel,
    input logic txd,
    input logic busy
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!txd && busy));

    p_sync_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel |-> !in_ready);

    p_ready_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> baud_tick);

    p_hold_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> ($stable(txd) && $stable(busy)));

    p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |-> !in_ready);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_tick(baud_tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .sync_sel (sync_sel),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/tb_uart_frame_tx.sv
// Bench: behavioural line model compared on every clock.
module tb_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] frame_mode = 2'b11;
    logic       par_off = 1'b1;
    logic [1:0] par_sel = 2'b00;
    logic       brk_en = 1'b0;
    logic       sync_sel = 1'b0;
    logic [2:0] bit_len = 3'd0;
    logic       txd;
    logic       busy;

    int    checks = 0;
    int    errors = 0;
    int    tick_div = 4;
    int    tdiv_cnt = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    bit    q[$];
    bit    m_line = 1'b1;
    bit    m_busy = 1'b0;

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .frame_mode(frame_mode), .par_off(par_off), .par_sel(par_sel),
        .brk_en(brk_en), .sync_sel(sync_sel), .bit_len(bit_len),
        .txd(txd), .busy(busy)
    );

    always #5 clk = ~clk;

    // Baud tick divider, one-cycle pulses.
    always @(negedge clk) begin
        if (tdiv_cnt >= tick_div - 1) tdiv_cnt = 0;
        else tdiv_cnt = tdiv_cnt + 1;
        baud_tick = (tdiv_cnt == 0);
    end

    // Push the expected bits of one frame from the requirement rules.
    task automatic push_frame();
        int  nc = frame_mode[1] ? 8 : 7;
        int  ns = frame_mode[0] ? 2 : 1;
        int  ones = 0;
        bit  bits[$];
        bits.push_back(1'b0);
        for (int i = 0; i < nc; i++) begin
            bits.push_back(in_data[i]);
            if (in_data[i]) ones++;
        end
        if (!par_off) begin
            case (par_sel)
                2'b00: bits.push_back(1'b0);
                2'b01: bits.push_back(1'b1);
                2'b10: bits.push_back((ones % 2) == 0);
                default: bits.push_back((ones % 2) == 1);
            endcase
        end
        for (int i = 0; i < ns; i++) bits.push_back(1'b1);
        foreach (bits[i]) q.push_back(brk_en ? 1'b0 : bits[i]);
    endtask

    // Compare outputs, then step the model across the next rising edge.
    always @(negedge clk) begin
        bit exp_ready;
        #1;
        exp_ready = baud_tick && !sync_sel && (q.size() == 0);
        if (chk_on) begin
            checks++;
            if (txd !== m_line) begin
                errors++;
                $display("FAIL R2 %s txd: actual=%b expected=%b at %0t", cur_req, txd, m_line, $time);
            end
            checks++;
            if (busy !== m_busy) begin
                errors++;
                $display("FAIL R12 %s busy: actual=%b expected=%b at %0t", cur_req, busy, m_busy, $time);
            end
            checks++;
            if (in_ready !== exp_ready) begin
                errors++;
                $display("FAIL R11 %s in_ready: actual=%b expected=%b at %0t", cur_req, in_ready, exp_ready, $time);
            end
        end
        if (!rst_n) begin
            q.delete();
            m_line = 1'b1;
            m_busy = 1'b0;
        end else if (baud_tick) begin
            if (exp_ready && in_valid) push_frame();
            if (q.size() > 0) begin
                m_line = q.pop_front();
                m_busy = 1'b1;
            end else begin
                m_line = 1'b1;
                m_busy = 1'b0;
            end
        end
    end

    // Offer one character and wait for the handshake.
    task automatic send(input logic [7:0] d, input logic [1:0] fm,
                        input logic po, input logic [1:0] ps, input logic bk);
        @(negedge clk);
        in_data = d; frame_mode = fm; par_off = po; par_sel = ps; brk_en = bk;
        in_valid = 1'b1;
        forever begin
            #2;
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (busy !== 1'b0 || q.size() != 0) @(negedge clk);
        repeat (2 * tick_div + 2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        checks++;
        if (txd !== 1'b1 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual=%b%b expected=10", txd, busy);
        end
        chk_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        cur_req = "R3";
        for (int m = 0; m < 4; m++) send(8'hA5, 2'(m), 1'b1, 2'b00, 1'b0);
        drain();

        cur_req = "R4";
        for (int p = 0; p < 4; p++) send(8'h3C, 2'b10, 1'b1, 2'(p), 1'b0);
        drain();

        cur_req = "R5";
        send(8'hFF, 2'b11, 1'b0, 2'b00, 1'b0);
        send(8'h00, 2'b00, 1'b0, 2'b01, 1'b0);
        drain();

        cur_req = "R6";
        send(8'h07, 2'b10, 1'b0, 2'b10, 1'b0);
        send(8'h03, 2'b10, 1'b0, 2'b10, 1'b0);
        send(8'h07, 2'b11, 1'b0, 2'b11, 1'b0);
        send(8'h81, 2'b00, 1'b0, 2'b11, 1'b0);
        drain();

        cur_req = "R7";
        send(8'hFF, 2'b11, 1'b0, 2'b10, 1'b1);
        send(8'h55, 2'b00, 1'b1, 2'b00, 1'b1);
        drain();

        cur_req = "R8";
        for (int b = 0; b < 8; b += 3) begin
            bit_len = 3'(b);
            send(8'h96, 2'b00, 1'b0, 2'b11, 1'b0);
        end
        drain();

        cur_req = "R9";
        sync_sel = 1'b1;
        @(negedge clk);
        in_data = 8'h12; in_valid = 1'b1;
        repeat (40) @(negedge clk);
        in_valid = 1'b0;
        sync_sel = 1'b0;
        drain();

        cur_req = "R10";
        send(8'hC3, 2'b11, 1'b0, 2'b10, 1'b0);
        in_data = 8'h00; frame_mode = 2'b00; par_off = 1'b1; brk_en = 1'b1;
        drain();
        brk_en = 1'b0;

        cur_req = "R11";
        tick_div = 1;
        send(8'h5A, 2'b10, 1'b0, 2'b01, 1'b0);
        send(8'hA5, 2'b01, 1'b1, 2'b00, 1'b0);
        drain();
        tick_div = 3;
        send(8'h0F, 2'b11, 1'b0, 2'b11, 1'b0);
        send(8'hF0, 2'b00, 1'b0, 2'b00, 1'b0);
        drain();

        finish_run();
    end
endmodule